// File: doc/BRIEF.md
# Scalable 64-bit System Counter

This block keeps a 64-bit system count that moves forward on pulses of a reference tick. Once enabled, the count gains exactly one per tick in unit mode. In scaled mode it gains a programmable 8.24 fixed-point step per tick instead. Whole units carried out of a 24-bit fraction accumulator go into the count, so the count can run at a non-integer fraction or multiple of the tick rate. A small 32-bit register bus handles control, status, the two count halves and the scale value. The full count is driven out as a registered 64-bit value for timers downstream.

A mode state machine holds the operating state. It has three states: HALTED, COUNT_UNIT and COUNT_SCALED. Writes to the control register fire its transitions:
- START_UNIT: HALTED to COUNT_UNIT.
- START_SCALED: HALTED to COUNT_SCALED.
- STOP: either counting state to HALTED.
- TO_SCALED: COUNT_UNIT to COUNT_SCALED.
- TO_UNIT: COUNT_SCALED to COUNT_UNIT.

Top module: `sysctr_top`

## Requirements
- R1: After reset the count is 0 and the block is HALTED. Status reads 1, control reads 0 and scale reads 0x01000000.
- R2: A write to offset 0x0 sets the mode. Bit 0 is the enable and bit 2 selects scaled counting, so the value 5 starts scaled counting. Control reads back bit 0 as "counting" and bit 2 as "counting scaled". A write with bit 0 clear halts the block.
- R3: While HALTED the count does not change on ticks. This includes a control write of 4, which has bit 2 set but bit 0 clear.
- R4: In COUNT_UNIT the count gains exactly 1 per tick, so 100 ticks give 100.
- R5: In COUNT_SCALED each tick adds the scale to a 24-bit fraction, and the integer carry goes into the count. With 1.0 = 0x01000000, a scale of 0x00100000 gives 10 over 160 ticks, 0x01800000 gives 6 over 4 ticks, and 0x02000000 gives 14 over 7 ticks.
- R6: The count low word reads at 0x8 and the high word at 0xC. The output `count_o` is registered and always equals {high, low}.
- R7: The low word carries into the high word. From 0x00000000_FFFFFFFF, one unit tick gives 0x00000001_00000000.
- R8: Bit 0 of status at 0x4 reads 1 while HALTED and 0 while counting.
- R9: A write to 0x8 or 0xC replaces that half of the count and clears the fraction accumulator.
- R10: A write to scale at 0x10 is accepted only while HALTED. While counting it is ignored: the scale reads back unchanged and counting continues at the old rate.
- R11: If a count write and a tick land in the same cycle, the written value wins and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference tick pulse, one clock wide |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| count_o | output | 64 | Registered system count |

## Verification
A software write to a count half and a reference tick can land in the same cycle, and then only one of them may update the count. The bench provokes this by raising `tick` together with a write of 0x50 to the low word while the block is in COUNT_UNIT. It judges the result by reading exactly 0x50 back, not 0x51. One further tick must then give 0x51, which shows the dropped tick left no pending step behind.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;

    typedef enum logic [1:0] {
        ST_HALTED = 2'd0,
        ST_UNIT   = 2'd1,
        ST_SCALED = 2'd2
    } mode_e;

    localparam logic [4:0] OFS_CTRL   = 5'h00;
    localparam logic [4:0] OFS_STATUS = 5'h04;
    localparam logic [4:0] OFS_CNT_LO = 5'h08;
    localparam logic [4:0] OFS_CNT_HI = 5'h0C;
    localparam logic [4:0] OFS_SCALE  = 5'h10;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_SC_BIT = 2;

endpackage

// File: rtl/sysctr_mode_fsm.sv
module sysctr_mode_fsm
    import sysctr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_wr_i,
    input  logic  wr_en_i,
    input  logic  wr_scaled_i,
    output mode_e mode_o,
    output logic  running_o,
    output logic  scaled_o
);

    mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED: begin
                if (ctrl_wr_i && wr_en_i)
                    state_d = wr_scaled_i ? ST_SCALED : ST_UNIT;   // START_SCALED / START_UNIT
            end
            ST_UNIT: begin
                if (ctrl_wr_i && !wr_en_i)     state_d = ST_HALTED; // STOP
                else if (ctrl_wr_i && wr_scaled_i) state_d = ST_SCALED; // TO_SCALED
            end
            ST_SCALED: begin
                if (ctrl_wr_i && !wr_en_i)     state_d = ST_HALTED; // STOP
                else if (ctrl_wr_i && !wr_scaled_i) state_d = ST_UNIT; // TO_UNIT
            end
            default: state_d = ST_HALTED;
        endcase
    end

    always_comb begin
        running_o = 1'b0;
        scaled_o  = 1'b0;
        unique case (state_q)
            ST_HALTED: ;
            ST_UNIT:   running_o = 1'b1;
            ST_SCALED: begin
                running_o = 1'b1;
                scaled_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mode_o = state_q;

    // R2: a control write with the enable clear always halts
    assert_stop_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && !wr_en_i) |=> (state_q == ST_HALTED));

    // R2: enable with scale select lands in the scaled state
    assert_start_scaled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && wr_en_i && wr_scaled_i) |=> (scaled_o && running_o));

endmodule

// File: rtl/sysctr_accum.sv
module sysctr_accum
    import sysctr_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int FRAC_W  = 24,
    parameter int SCALE_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  mode_e                mode_i,
    input  logic [SCALE_W-1:0]   scale_i,
    input  logic                 wr_lo_i,
    input  logic                 wr_hi_i,
    input  logic [BUS_W-1:0]     wdata_i,
    output logic [2*BUS_W-1:0]   count_o
);

    localparam int CNT_W = 2 * BUS_W;
    localparam int SUM_W = SCALE_W + 1;
    localparam int INC_W = SUM_W - FRAC_W;

    logic [CNT_W-1:0]  count_q;
    logic [FRAC_W-1:0] frac_q, frac_d;
    logic [INC_W-1:0]  inc;
    logic [SUM_W-1:0]  sum;
    logic              sw_wr;

    assign sw_wr = wr_lo_i | wr_hi_i;
    assign sum   = {{(SUM_W-FRAC_W){1'b0}}, frac_q} + {1'b0, scale_i};

    always_comb begin
        inc    = '0;
        frac_d = frac_q;
        unique case (mode_i)
            ST_HALTED: ;
            ST_UNIT:   inc = {{(INC_W-1){1'b0}}, 1'b1};
            ST_SCALED: begin
                inc    = sum[SUM_W-1:FRAC_W];
                frac_d = sum[FRAC_W-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            frac_q  <= '0;
        end else if (sw_wr) begin
            if (wr_lo_i) count_q[BUS_W-1:0]     <= wdata_i;
            if (wr_hi_i) count_q[CNT_W-1:BUS_W] <= wdata_i;
            frac_q <= '0;
        end else if (tick_i && mode_i != ST_HALTED) begin
            count_q <= count_q + {{(CNT_W-INC_W){1'b0}}, inc};
            frac_q  <= frac_d;
        end
    end

    assign count_o = count_q;

    // R3: no movement while halted and not written
    assert_halt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ST_HALTED && !sw_wr) |=> $stable(count_q));

    // R4: exactly one step per tick in unit mode
    assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_i == ST_UNIT && !sw_wr) |=>
            (count_q == $past(count_q) + {{(CNT_W-1){1'b0}}, 1'b1}));

    // R9: a software count write leaves the fraction empty
    assert_frac_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (frac_q == '0));

endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
    import sysctr_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 5,
    parameter int FRAC_W  = 24,
    parameter int SCALE_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic [2*BUS_W-1:0]   count_o
);

    localparam int CNT_W = 2 * BUS_W;
    localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1) << FRAC_W;

    mode_e              mode;
    logic               running, scaled;
    logic               wr_ctrl, wr_lo, wr_hi, wr_scale;
    logic [SCALE_W-1:0] scale_q;
    logic [CNT_W-1:0]   count;

    assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_lo    = bus_we && (bus_addr == ADDR_W'(OFS_CNT_LO));
    assign wr_hi    = bus_we && (bus_addr == ADDR_W'(OFS_CNT_HI));
    assign wr_scale = bus_we && (bus_addr == ADDR_W'(OFS_SCALE));

    sysctr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_i   (wr_ctrl),
        .wr_en_i     (bus_wdata[CTRL_EN_BIT]),
        .wr_scaled_i (bus_wdata[CTRL_SC_BIT]),
        .mode_o      (mode),
        .running_o   (running),
        .scaled_o    (scaled)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                   scale_q <= SCALE_ONE;
        else if (wr_scale && !running) scale_q <= bus_wdata[SCALE_W-1:0];
    end

    sysctr_accum #(
        .BUS_W   (BUS_W),
        .FRAC_W  (FRAC_W),
        .SCALE_W (SCALE_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .mode_i  (mode),
        .scale_i (scale_q),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (bus_wdata),
        .count_o (count)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[CTRL_EN_BIT] = running;
                bus_rdata[CTRL_SC_BIT] = scaled;
            end
            ADDR_W'(OFS_STATUS): bus_rdata[0] = !running;
            ADDR_W'(OFS_CNT_LO): bus_rdata    = count[BUS_W-1:0];
            ADDR_W'(OFS_CNT_HI): bus_rdata    = count[CNT_W-1:BUS_W];
            ADDR_W'(OFS_SCALE):  bus_rdata    = BUS_W'(scale_q);
            default: bus_rdata = '0;
        endcase
    end

    assign count_o = count;

    // R10: scale writes while counting are dropped
    assert_scale_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_scale && running) |=> $stable(scale_q));

    // R11: a count write beats a tick in the same cycle
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && tick) |=> (count_o[BUS_W-1:0] == $past(bus_wdata)));

endmodule

// File: tb/sysctr_top_tb_top.sv
module sysctr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    sysctr_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_o   (count_o)
    );

    typedef struct packed {
        logic [2:0]  ctrl;
        logic [31:0] scale;
        int unsigned nticks;
        logic [31:0] expect_cnt;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 32'h0100_0000, 100, 32'd100},  // R4 unit
        '{3'd5, 32'h0010_0000, 160, 32'd10},   // R5 one sixteenth
        '{3'd5, 32'h0180_0000, 4,   32'd6},    // R5 one and a half
        '{3'd5, 32'h0200_0000, 7,   32'd14},   // R5 two
        '{3'd0, 32'h0100_0000, 50,  32'd0},    // R3 disabled
        '{3'd4, 32'h0100_0000, 50,  32'd0}     // R3 scale select only
    };

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            report();
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(int unsigned n);
        for (int unsigned i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic clear_count();
        wr(5'h00, 32'd0);
        wr(5'h08, 32'd0);
        wr(5'h0C, 32'd0);
    endtask

    logic [31:0] r;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 count", count_o, 64'd0);
        rd(5'h04, r); check("R1 status", 64'(r), 64'd1);
        rd(5'h00, r); check("R1 ctrl", 64'(r), 64'd0);
        rd(5'h10, r); check("R1 scale", 64'(r), 64'h0100_0000);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            clear_count();
            wr(5'h10, VECS[v].scale);
            wr(5'h00, {29'd0, VECS[v].ctrl});
            ticks(VECS[v].nticks);
            wr(5'h00, 32'd0);
            rd(5'h08, r); check("R4/R5/R3 table low", 64'(r), 64'(VECS[v].expect_cnt));
            rd(5'h0C, r); check("R6 table high", 64'(r), 64'd0);
            check("R6 table count_o", count_o, 64'(VECS[v].expect_cnt));
        end

        // R2 / R8 readback while counting scaled
        wr(5'h00, 32'd5);
        rd(5'h00, r); check("R2 ctrl scaled", 64'(r), 64'd5);
        rd(5'h04, r); check("R8 status running", 64'(r), 64'd0);
        wr(5'h00, 32'd1);
        rd(5'h00, r); check("R2 ctrl unit", 64'(r), 64'd1);
        wr(5'h00, 32'd0);
        rd(5'h04, r); check("R8 status halted", 64'(r), 64'd1);

        // R7 carry
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'd0);
        wr(5'h00, 32'd1);
        ticks(1);
        wr(5'h00, 32'd0);
        check("R7 carry count_o", count_o, 64'h1_0000_0000);
        rd(5'h0C, r); check("R7 carry high", 64'(r), 64'd1);

        // R9 write clears fraction
        clear_count();
        wr(5'h10, 32'h0010_0000);
        wr(5'h00, 32'd5);
        ticks(8);
        wr(5'h00, 32'd0);
        wr(5'h08, 32'd0);
        wr(5'h00, 32'd5);
        ticks(8);
        check("R9 no carry after clear", count_o, 64'd0);
        ticks(8);
        check("R9 carry after 16", count_o, 64'd1);
        wr(5'h00, 32'd0);

        // R10 scale write ignored while counting
        clear_count();
        wr(5'h10, 32'h0100_0000);
        wr(5'h00, 32'd5);
        wr(5'h10, 32'h0400_0000);
        rd(5'h10, r); check("R10 scale unchanged", 64'(r), 64'h0100_0000);
        ticks(3);
        check("R10 rate unchanged", count_o, 64'd3);
        wr(5'h00, 32'd0);

        // R11 write and tick in same cycle
        clear_count();
        wr(5'h00, 32'd1);
        @(negedge clk);
        tick = 1'b1; bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h50;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
        rd(5'h08, r); check("R11 write wins", 64'(r), 64'h50);
        ticks(1);
        check("R11 next tick", count_o, 64'h51);
        wr(5'h00, 32'd0);

        report();
    end

endmodule